// File: doc/BRIEF.md
# Maskable and Non-Maskable Interrupt Aggregator

This block gathers interrupt requests from a set of peripherals into one level-sensitive interrupt line for a CPU. Each peripheral raises its request by pulsing its bits on the set input and withdraws it by pulsing them on the clear input. The requests are held in a pending vector. The low group of pending bits is maskable through an enable register that the CPU writes. The bits above that group cannot be masked.

The CPU line is a registered level computed from the pending vector and the enable register. The CPU taking the exception has no effect on it. The line falls only once the peripherals have withdrawn every request that counts toward it. When several requests are outstanding, the line therefore stays up until the last of them is cleared, and no request is lost. The pending vector and the enable register are both visible on output ports for readback.

Top module: `irq_merge`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the pending vector reads 0, the enable register reads 0 and the CPU line is low.
- R2: A bit that is high on `set_i` at a clock edge is 1 in `pend_o` after that edge.
- R3: A bit that is high on `clr_i` and low on `set_i` at a clock edge is 0 in `pend_o` after that edge. Bits that are low on both inputs keep their value.
- R4: When `set_i` and `clr_i` both carry the same bit in one cycle, that bit ends up set.
- R5: Pending bits 7..0 drive the CPU line only where the bit at the same position of `en_o` is 1.
- R6: Any pending bit at position 8 or higher drives the CPU line, whatever the enable register holds.
- R7: The CPU line is low exactly when no enabled low bit and no high bit is pending. With several bits pending it stays high until the last of them is cleared.
- R8: A write with `en_we` high loads `en_wdata` into the enable register. Without a write the enable register holds its value. The line reflects the new mask on the same edge, so unmasking a bit that is already pending raises the line one cycle after the write.
- R9: The CPU line is registered. A change on the inputs shows up on `cpu_irq_o` only after the next rising clock edge, never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_i | input | 16 | Bits to set in the pending vector |
| clr_i | input | 16 | Bits to clear in the pending vector |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | New enable mask for pending bits 7..0 |
| pend_o | output | 16 | Pending vector readback |
| en_o | output | 8 | Enable register readback |
| cpu_irq_o | output | 1 | Level interrupt line to the CPU |

## Verification
The assertions assume that the set, clear and write inputs are synchronous to the clock and stable around each rising edge. They also assume that reset is released long enough before an edge for that edge to be a normal update. The bench meets this by changing every input on falling edges only. It holds reset for several cycles and releases it on a falling edge. The assertions also rely on nothing else writing the pending vector, which holds because the only paths into it are the two pulse inputs.

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NUM = 16,
  parameter int LOW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  input  logic           en_we,
  input  logic [LOW-1:0] en_wdata,
  output logic [NUM-1:0] pend_o,
  output logic [LOW-1:0] en_o,
  output logic           cpu_irq_o
);
  localparam int HIGH = NUM - LOW;

  logic [NUM-1:0] pend_q, pend_d;
  logic [LOW-1:0] en_q, en_d;
  logic           irq_q, irq_d;

  assign pend_d = (pend_q & ~clr_i) | set_i;
  assign en_d   = en_we ? en_wdata : en_q;

  generate
    if (HIGH > 0) begin : g_nmi
      assign irq_d = (|(pend_d[LOW-1:0] & en_d)) | (|pend_d[NUM-1:LOW]);
    end else begin : g_mask_only
      assign irq_d = |(pend_d[LOW-1:0] & en_d);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_o    = pend_q;
  assign en_o      = en_q;
  assign cpu_irq_o = irq_q;
endmodule

module irq_merge_chk #(
  parameter int NUM = 16,
  parameter int LOW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NUM-1:0] set_i,
  input logic [NUM-1:0] clr_i,
  input logic           en_we,
  input logic [LOW-1:0] en_wdata,
  input logic [NUM-1:0] pend_o,
  input logic [LOW-1:0] en_o,
  input logic           cpu_irq_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |-> (pend_o == '0 && en_o == '0 && !cpu_irq_o));

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

  // R3
  hold_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i | clr_i) == '0) |=> $stable(pend_o));

  // R5
  line_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o == ((|(pend_o[LOW-1:0] & en_o)) || (|(pend_o >> LOW))));

  // R7
  line_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_irq_o) |-> ((pend_o[LOW-1:0] & en_o) == '0 && (pend_o >> LOW) == '0));

  // R8
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_o == $past(en_wdata)));

  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_o));
endmodule

bind irq_merge irq_merge_chk #(.NUM(NUM), .LOW(LOW)) u_chk (.*);

// File: tb/sim_irq_merge.sv
module sim_irq_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] set_i = '0, clr_i = '0;
  logic        en_we = 1'b0;
  logic [7:0]  en_wdata = '0;
  logic [15:0] pend_o;
  logic [7:0]  en_o;
  logic        cpu_irq_o;

  int total = 0, bad = 0;
  logic [15:0] mp = '0;
  logic [7:0]  me = '0;

  always #5ns clk = ~clk;

  irq_merge u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic model_irq();
    return ((mp[7:0] & me) != 0) || (mp[15:8] != 0);
  endfunction

  task automatic step(string req, logic [15:0] s, logic [15:0] c, logic w, logic [7:0] d);
    set_i = s; clr_i = c; en_we = w; en_wdata = d;
    @(negedge clk);
    mp = (mp & ~c) | s;
    if (w) me = d;
    check({req, " pend"}, 32'(pend_o), 32'(mp));
    check({req, " en"}, 32'(en_o), 32'(me));
    check({req, " irq"}, 32'(cpu_irq_o), 32'(model_irq()));
    set_i = '0; clr_i = '0; en_we = 1'b0;
  endtask

  initial begin
    #2ms;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pend", 32'(pend_o), 0);
    check("R1 reset en", 32'(en_o), 0);
    check("R1 reset irq", 32'(cpu_irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset irq", 32'(cpu_irq_o), 0);

    // R5 R6: each bit alone, with the mask fully closed then fully open
    for (int m = 0; m < 2; m++) begin
      step("R8 mask", '0, '0, 1'b1, m ? 8'hFF : 8'h00);
      for (int i = 0; i < 16; i++) begin
        step(i < 8 ? "R5 single" : "R6 single", 16'(1) << i, '0, 1'b0, '0);
        step("R3 single clr", '0, 16'(1) << i, 1'b0, '0);
      end
    end

    // R5: every enable pattern against a fixed low pending byte
    step("R2 preload", 16'h00A5, '0, 1'b0, '0);
    for (int e = 0; e < 256; e++) step("R5 sweep", '0, '0, 1'b1, 8'(e));

    // R4: set wins over clear on the same bit
    step("R2 fill", 16'hFFFF, '0, 1'b0, '0);
    step("R4 collide", 16'h0F0F, 16'hFFFF, 1'b0, '0);
    check("R4 result", 32'(pend_o), 32'h0F0F);

    // R7: clear one at a time, line holds until the last
    step("R2 fill", 16'hFFFF, '0, 1'b1, 8'hFF);
    for (int i = 0; i < 16; i++) begin
      step("R7 drain", '0, 16'(1) << i, 1'b0, '0);
      check("R7 line", 32'(cpu_irq_o), (i < 15) ? 1 : 0);
    end

    // R8: unmasking an already pending bit
    step("R8 close", '0, '0, 1'b1, 8'h00);
    step("R8 pend masked", 16'h0004, '0, 1'b0, '0);
    check("R8 masked low", 32'(cpu_irq_o), 0);
    step("R8 unmask", '0, '0, 1'b1, 8'h04);
    check("R8 unmask high", 32'(cpu_irq_o), 1);
    step("R8 remask", '0, '0, 1'b1, 8'hFB);
    check("R8 remask low", 32'(cpu_irq_o), 0);

    // R9: no change before the edge
    step("R3 clean", '0, 16'hFFFF, 1'b0, '0);
    set_i = 16'h0100;
    #1ns;
    check("R9 before edge", 32'(cpu_irq_o), 0);
    mp = mp | 16'h0100;
    @(negedge clk);
    set_i = '0;
    check("R9 after edge", 32'(cpu_irq_o), 1);
    step("R6 held", '0, '0, 1'b1, 8'h00);

    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule